// File: doc/BRIEF.md
# NAND Page ECC Step Sequencer

This block runs the data phase of an error-corrected NAND page read. It starts once the read command has already gone to the device. The page arrives as a byte stream and is split into equal ECC steps. For each step the block can clear an external ECC calculator, feed it the step's bytes and then collect the code it computes. The spare (out-of-band) area of the page is captured in full. The stored ECC bytes are then picked out of that area through a position table supplied at a port, which lets the code bytes sit anywhere in the spare area. For each step, the stored code and the computed code are presented together on a correction request port. The corrector can answer with a single byte repair, which is applied to the internally buffered page before that data leaves on the output stream.

Two orders are offered, and the order is sampled at start. In data-first order, every step is read and its code computed, then the spare area is read, then all corrections run in step order, and only then is the page released. In spare-first order, the spare area is read first, and a command-reissue handshake asks the surrounding logic to send a new read for the page data. Each step is then read, computed, corrected and released before the next step begins.

Top module: `nand_ecc_page_seq`

## Requirements
- R1: The page of PAGE_BYTES is read as STEPS = PAGE_BYTES/STEP_BYTES steps. Step k's bytes are buffered at byte offsets k*STEP_BYTES onward. The calculator code taken at the k-th calc_ack is the code presented as cor_calc for step k. There are STEPS*ECC_BYTES stored code bytes in total.
- R2: With hw_ecc set at start, calc_clr is high for one cycle before the first byte of every step. With hw_ecc clear, calc_clr never rises. calc_en is high exactly in the cycles where a page data byte is taken (rd_valid and rd_ready high). calc_byte then equals rd_data. Spare-area bytes are never fed to the calculator.
- R3: In data-first order (oob_first low at start), all page bytes and then all OOB_BYTES spare bytes are taken before the first cor_req. Correction requests follow for steps 0 to STEPS-1 in order, and output starts only after the last of them is acknowledged.
- R4: In spare-first order, the spare bytes are taken first and cmd_req is raised next, held until cmd_ack. After that, each step is read, its code computed, its correction requested and its bytes released, before any byte of the following step is taken.
- R5: Stored code byte i is the spare byte whose arrival index (0 for the first spare byte received) is table entry i. Entry i is pos_tbl[i*PW +: PW], with PW = clog2(OOB_BYTES). For step k, cor_stored bits [j*8 +: 8] hold stored byte k*ECC_BYTES+j. cor_calc uses the same byte layout as calc_code.
- R6: On a cor_ack with cor_fix high, the buffered byte at k*STEP_BYTES+cor_off is XORed with cor_mask before it is released.
- R7: A cor_ack with cor_fix low changes no data, whatever cor_off and cor_mask hold. The sequence still processes every step.
- R8: Page bytes leave in ascending address order on out_valid/out_ready. While out_ready is low, out_valid stays high and out_data stays unchanged.
- R9: After reset, every request, valid and done output is low. done pulses high for exactly one cycle after the last page byte has been released, which always follows the final correction acknowledge. The block is then idle.
- R10: calc_req, cor_req and cmd_req stay high until acknowledged, and cor_step stays stable while waiting. At most one of rd_ready, calc_req, cor_req, cmd_req and out_valid is high in any cycle.
- R11: start is ignored unless the block is idle. oob_first and hw_ecc are sampled only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page data phase (taken when idle) |
| oob_first | input | 1 | 1 selects spare-first order, 0 data-first |
| hw_ecc | input | 1 | 1 clears the calculator before each step |
| pos_tbl | input | STEPS*ECC_BYTES*PW | Spare-area position of each stored code byte |
| rd_valid | input | 1 | Device byte available |
| rd_data | input | 8 | Device byte |
| rd_ready | output | 1 | Block takes a device byte |
| cmd_req | output | 1 | Request to reissue the page read command |
| cmd_ack | input | 1 | Command reissued |
| calc_clr | output | 1 | Calculator read-mode clear |
| calc_en | output | 1 | Calculator byte strobe |
| calc_byte | output | 8 | Calculator byte |
| calc_req | output | 1 | Request the computed code of the step |
| calc_ack | input | 1 | Computed code valid |
| calc_code | input | ECC_BYTES*8 | Computed code |
| cor_req | output | 1 | Correction request for cor_step |
| cor_step | output | KW | Step under correction |
| cor_stored | output | ECC_BYTES*8 | Code read from the spare area |
| cor_calc | output | ECC_BYTES*8 | Code computed over the step |
| cor_ack | input | 1 | Correction answered |
| cor_fix | input | 1 | Apply a byte repair |
| cor_off | input | SW | Byte offset within the step |
| cor_mask | input | 8 | XOR mask of the repair |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the byte |
| done | output | 1 | One-cycle end-of-page pulse |

## Verification
The assertions check on every cycle the properties that depend only on what is visible at the ports:
- requests hold until acknowledged, and the output stays stable under backpressure;
- at most one port-side activity happens in a cycle;
- every calculator clear is followed by a read;
- no clear occurs in software mode;
- in data-first order, the full page and spare area have been taken before any correction, and in spare-first order, the command reissue comes exactly after the spare bytes.

Only the bench scenarios can show the data-dependent behaviour. This covers the gathering of stored bytes through many tables, the pairing of each step with its computed code, each repaired byte position, ignored repairs, the per-step interleaving of the spare-first order, and the rejection of a start during a run.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_DATA, S_CALC, S_OOB, S_CMD, S_COR, S_OUT, S_DONE
  } seq_st_e;
endpackage

// File: rtl/ecc_page_buf.sv
// Page byte store with a write/XOR-repair port and an asynchronous read.
module ecc_page_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          flip,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= flip ? (mem[addr] ^ wdata) : wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ecc_oob_gather.sv
// Captures the spare area and selects one step's stored code through the table.
module ecc_oob_gather #(
  parameter int OOB_BYTES = 16,
  parameter int ECC_BYTES = 2,
  parameter int STEPS     = 4,
  parameter int PW        = $clog2(OOB_BYTES),
  parameter int KW        = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                          clk,
  input  logic                          cap_en,
  input  logic [PW-1:0]                 cap_idx,
  input  logic [7:0]                    cap_byte,
  input  logic [KW-1:0]                 step,
  input  logic [STEPS*ECC_BYTES*PW-1:0] pos_tbl,
  output logic [ECC_BYTES*8-1:0]        stored
);
  logic [7:0] oob_q [OOB_BYTES];

  always_ff @(posedge clk) begin
    if (cap_en) oob_q[cap_idx] <= cap_byte;
  end

  for (genvar j = 0; j < ECC_BYTES; j++) begin : g_byte
    logic [PW-1:0] sel;
    assign sel = pos_tbl[(int'(step) * ECC_BYTES + j) * PW +: PW];
    assign stored[j*8 +: 8] = oob_q[sel];
  end
endmodule

// File: rtl/ecc_code_store.sv
// Holds the computed code of every step until its correction.
module ecc_code_store #(
  parameter int STEPS = 4,
  parameter int CW    = 16,
  parameter int KW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [KW-1:0] wr_step,
  input  logic [CW-1:0] wr_code,
  input  logic [KW-1:0] rd_step,
  output logic [CW-1:0] rd_code
);
  logic [CW-1:0] code_q [STEPS];

  always_ff @(posedge clk) begin
    if (wr_en) code_q[wr_step] <= wr_code;
  end

  assign rd_code = code_q[rd_step];
endmodule

// File: rtl/nand_ecc_page_seq.sv
module nand_ecc_page_seq
  import nand_ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int STEP_BYTES = 4,
  parameter int ECC_BYTES  = 2,
  parameter int OOB_BYTES  = 16,
  localparam int STEPS = PAGE_BYTES / STEP_BYTES,
  localparam int TOT   = STEPS * ECC_BYTES,
  localparam int CW    = ECC_BYTES * 8,
  localparam int PW    = $clog2(OOB_BYTES),
  localparam int SW    = $clog2(STEP_BYTES),
  localparam int KW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              oob_first,
  input  logic              hw_ecc,
  input  logic [TOT*PW-1:0] pos_tbl,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              rd_ready,
  output logic              cmd_req,
  input  logic              cmd_ack,
  output logic              calc_clr,
  output logic              calc_en,
  output logic [7:0]        calc_byte,
  output logic              calc_req,
  input  logic              calc_ack,
  input  logic [CW-1:0]     calc_code,
  output logic              cor_req,
  output logic [KW-1:0]     cor_step,
  output logic [CW-1:0]     cor_stored,
  output logic [CW-1:0]     cor_calc,
  input  logic              cor_ack,
  input  logic              cor_fix,
  input  logic [SW-1:0]     cor_off,
  input  logic [7:0]        cor_mask,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              done
);
  localparam int AW   = $clog2(PAGE_BYTES);
  localparam int MAXB = (PAGE_BYTES > OOB_BYTES) ? PAGE_BYTES : OOB_BYTES;
  localparam int IW   = $clog2(MAXB) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_st_e       st_q, st_d;
  logic [KW-1:0] step_q, step_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          of_q, hw_q;
  logic          go, rd_fire, last_step;
  logic [AW-1:0] base, drain_last, buf_addr;
  logic          buf_we, buf_flip;
  logic [7:0]    buf_wdata;

  assign go        = (st_q == S_IDLE) && start;
  assign rd_ready  = (st_q == S_DATA) || (st_q == S_OOB);
  assign rd_fire   = rd_ready && rd_valid;
  assign last_step = (step_q == KW'(STEPS - 1));
  assign base      = AW'(step_q) * AW'(STEP_BYTES);
  assign drain_last = of_q ? (base + AW'(STEP_BYTES - 1)) : AW'(PAGE_BYTES - 1);

  assign calc_clr  = (st_q == S_CLR) && hw_q;
  assign calc_en   = (st_q == S_DATA) && rd_valid;
  assign calc_byte = rd_data;
  assign calc_req  = (st_q == S_CALC);
  assign cmd_req   = (st_q == S_CMD);
  assign cor_req   = (st_q == S_COR);
  assign cor_step  = step_q;
  assign out_valid = (st_q == S_OUT);
  assign done      = (st_q == S_DONE);

  // next-state process
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    idx_d  = idx_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d   = oob_first ? S_OOB : S_CLR;
        step_d = '0;
        idx_d  = '0;
      end
      S_CLR: begin
        st_d  = S_DATA;
        idx_d = '0;
      end
      S_DATA: if (rd_fire) begin
        if (idx_q == IW'(STEP_BYTES - 1)) begin
          st_d  = S_CALC;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_CALC: if (calc_ack) begin
        if (of_q)           st_d = S_COR;
        else if (last_step) begin
          st_d  = S_OOB;
          idx_d = '0;
        end else begin
          st_d   = S_CLR;
          step_d = step_q + 1'b1;
        end
      end
      S_OOB: if (rd_fire) begin
        if (idx_q == IW'(OOB_BYTES - 1)) begin
          idx_d  = '0;
          step_d = '0;
          st_d   = of_q ? S_CMD : S_COR;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_CMD: if (cmd_ack) begin
        st_d   = S_CLR;
        step_d = '0;
      end
      S_COR: if (cor_ack) begin
        if (of_q) begin
          st_d  = S_OUT;
          idx_d = IW'(base);
        end else if (last_step) begin
          st_d  = S_OUT;
          idx_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      S_OUT: if (out_ready) begin
        if (AW'(idx_q) == drain_last) begin
          if (of_q && !last_step) begin
            st_d   = S_CLR;
            step_d = step_q + 1'b1;
          end else begin
            st_d = S_DONE;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      idx_q  <= '0;
      of_q   <= 1'b0;
      hw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      idx_q  <= idx_d;
      if (go) begin
        of_q <= oob_first;
        hw_q <= hw_ecc;
      end
    end
  end

  // buffer port: step bytes while reading, XOR repair on correction
  always_comb begin
    buf_we    = 1'b0;
    buf_flip  = 1'b0;
    buf_addr  = base + AW'(idx_q);
    buf_wdata = rd_data;
    if ((st_q == S_DATA) && rd_fire) begin
      buf_we = 1'b1;
    end else if ((st_q == S_COR) && cor_ack && cor_fix) begin
      buf_we    = 1'b1;
      buf_flip  = 1'b1;
      buf_addr  = base + AW'(cor_off);
      buf_wdata = cor_mask;
    end
  end

  ecc_page_buf #(.DEPTH(PAGE_BYTES), .AW(AW)) u_buf (
    .clk   (clk),
    .wr_en (buf_we),
    .flip  (buf_flip),
    .addr  (buf_addr),
    .wdata (buf_wdata),
    .raddr (AW'(idx_q)),
    .rdata (out_data)
  );

  ecc_oob_gather #(
    .OOB_BYTES(OOB_BYTES), .ECC_BYTES(ECC_BYTES), .STEPS(STEPS), .PW(PW), .KW(KW)
  ) u_gather (
    .clk      (clk),
    .cap_en   ((st_q == S_OOB) && rd_fire),
    .cap_idx  (PW'(idx_q)),
    .cap_byte (rd_data),
    .step     (step_q),
    .pos_tbl  (pos_tbl),
    .stored   (cor_stored)
  );

  ecc_code_store #(.STEPS(STEPS), .CW(CW), .KW(KW)) u_codes (
    .clk     (clk),
    .wr_en   (calc_req && calc_ack),
    .wr_step (step_q),
    .wr_code (calc_code),
    .rd_step (step_q),
    .rd_code (cor_calc)
  );
endmodule

// File: rtl/nand_ecc_page_seq_chk.sv
module nand_ecc_page_seq_chk #(
  parameter int PAGE_BYTES = 16,
  parameter int OOB_BYTES  = 16,
  parameter int KW         = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          oob_first,
  input logic          hw_ecc,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic          calc_clr,
  input logic          calc_req,
  input logic          calc_ack,
  input logic          cor_req,
  input logic          cor_ack,
  input logic [KW-1:0] cor_step,
  input logic          cmd_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          done
);
  localparam int CNTW = $clog2(PAGE_BYTES + OOB_BYTES + 1) + 1;

  logic            busy_m, of_m, hw_m;
  logic [CNTW-1:0] taken_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m  <= 1'b0;
      of_m    <= 1'b0;
      hw_m    <= 1'b0;
      taken_m <= '0;
    end else begin
      if (start && !busy_m) begin
        busy_m  <= 1'b1;
        of_m    <= oob_first;
        hw_m    <= hw_ecc;
        taken_m <= '0;
      end else begin
        if (done) busy_m <= 1'b0;
        if (rd_ready && rd_valid) taken_m <= taken_m + 1'b1;
      end
    end
  end

  AST_CLR_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    calc_clr |=> rd_ready); // R2
  AST_CLR_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    calc_clr |-> hw_m); // R2
  AST_COR_AFTER_ALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_req && !of_m) |-> (taken_m == CNTW'(PAGE_BYTES + OOB_BYTES))); // R3
  AST_CMD_AFTER_OOB: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (of_m && (taken_m == CNTW'(OOB_BYTES)))); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_COR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_req && !cor_ack) |=> (cor_req && $stable(cor_step))); // R10
  AST_CALC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_req && !calc_ack) |=> calc_req); // R10
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ready, calc_req, cor_req, cmd_req, out_valid})); // R10
endmodule

bind nand_ecc_page_seq nand_ecc_page_seq_chk #(
  .PAGE_BYTES(PAGE_BYTES), .OOB_BYTES(OOB_BYTES), .KW(KW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .oob_first(oob_first), .hw_ecc(hw_ecc),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .calc_clr(calc_clr),
  .calc_req(calc_req), .calc_ack(calc_ack), .cor_req(cor_req), .cor_ack(cor_ack),
  .cor_step(cor_step), .cmd_req(cmd_req), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/test_nand_ecc_page_seq.sv
module test_nand_ecc_page_seq;
  localparam int PAGE = 16, STEP = 4, ECCB = 2, OOB = 16;
  localparam int STEPS = PAGE / STEP, TOT = STEPS * ECCB;
  localparam int PW = 4, KW = 2, SW = 2, CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, oob_first, hw_ecc;
  logic [TOT*PW-1:0] pos_tbl;
  logic rd_valid, rd_ready, cmd_req, cmd_ack, calc_clr, calc_en, calc_req, calc_ack;
  logic [7:0] rd_data, calc_byte, cor_mask, out_data;
  logic [CW-1:0] calc_code, cor_stored, cor_calc;
  logic cor_req, cor_ack, cor_fix, out_valid, out_ready, done;
  logic [KW-1:0] cor_step;
  logic [SW-1:0] cor_off;

  nand_ecc_page_seq #(.PAGE_BYTES(PAGE), .STEP_BYTES(STEP), .ECC_BYTES(ECCB),
                      .OOB_BYTES(OOB)) i_nand_ecc_page_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .oob_first(oob_first), .hw_ecc(hw_ecc),
    .pos_tbl(pos_tbl), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .calc_clr(calc_clr), .calc_en(calc_en),
    .calc_byte(calc_byte), .calc_req(calc_req), .calc_ack(calc_ack),
    .calc_code(calc_code), .cor_req(cor_req), .cor_step(cor_step),
    .cor_stored(cor_stored), .cor_calc(cor_calc), .cor_ack(cor_ack),
    .cor_fix(cor_fix), .cor_off(cor_off), .cor_mask(cor_mask),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] page_ref [PAGE];
  logic [7:0] page_dev [PAGE];
  logic [7:0] oob_img  [OOB];
  logic [7:0] strm     [PAGE+OOB];
  logic [CW-1:0] calc_mdl [STEPS];

  // code = {sum, xor} of the step's bytes
  function automatic logic [15:0] code_of(input bit dev, input int k);
    logic [7:0] s, x;
    s = 8'h00; x = 8'h00;
    for (int b = 0; b < STEP; b++) begin
      s = s + (dev ? page_dev[k*STEP+b] : page_ref[k*STEP+b]);
      x = x ^ (dev ? page_dev[k*STEP+b] : page_ref[k*STEP+b]);
    end
    return {s, x};
  endfunction

  task automatic run_case(input bit of, input bit hw, input int err, input bit fixable,
                          input int mul, input int offs, input int seed);
    int idx, dcount, ncalc, ncor, nout, clr_cnt, cyc;
    logic [7:0] acc_s, acc_x, expb;
    bit isdata, exp_en, fin;
    logic [15:0] c;
    // build page, spare area and stream
    for (int i = 0; i < PAGE; i++) begin
      page_ref[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed << 2));
      page_dev[i] = page_ref[i] ^ ((i == err) ? 8'h5A : 8'h00);
    end
    for (int i = 0; i < OOB; i++) oob_img[i] = 8'(8'hC0 + i);
    for (int i = 0; i < TOT; i++) pos_tbl[i*PW +: PW] = PW'((i * mul + offs) % OOB);
    for (int k = 0; k < STEPS; k++) begin
      c = code_of(1'b0, k);
      oob_img[(2*k*mul + offs) % OOB]       = c[7:0];
      oob_img[((2*k+1)*mul + offs) % OOB]   = c[15:8];
    end
    for (int i = 0; i < PAGE + OOB; i++)
      strm[i] = of ? ((i < OOB) ? oob_img[i] : page_dev[i-OOB])
                   : ((i < PAGE) ? page_dev[i] : oob_img[i-PAGE]);
    idx = 0; dcount = 0; ncalc = 0; ncor = 0; nout = 0; clr_cnt = 0; cyc = 0;
    acc_s = 0; acc_x = 0; fin = 0;
    @(negedge clk);
    start = 1'b1; oob_first = of; hw_ecc = hw;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      start = (cyc == 6);        // R11: ignored while running
      oob_first = ~of;           // R11: mode sampled only at start
      hw_ecc = ~hw;
      if (cyc > 3000) begin
        chk(1'b0, "R9 run did not finish", cyc, 0);
        fin = 1;
      end else if (done) begin
        chk(nout == PAGE, "R9 bytes released before done", nout, PAGE);
        chk(ncor == STEPS, "R7 all steps corrected", ncor, STEPS);
        chk(clr_cnt == (hw ? STEPS : 0), "R2 clear count", clr_cnt, hw ? STEPS : 0);
        fin = 1;
      end else begin
        if (calc_clr) begin
          clr_cnt++;
          chk(dcount == ncalc * STEP, "R2 clear before step bytes", dcount, ncalc * STEP);
        end
        rd_valid  = (cyc % 3) != 2;
        rd_data   = (idx < PAGE + OOB) ? strm[idx] : 8'h00;
        calc_ack  = calc_req && (cyc % 2 == 0);
        calc_code = {acc_s, acc_x};
        cmd_ack   = cmd_req;
        cor_ack   = cor_req && (cyc % 2 == 1);
        if (err >= 0 && fixable && (err / STEP) == ncor) begin
          cor_fix = 1'b1; cor_off = SW'(err % STEP); cor_mask = 8'h5A;
        end else begin
          cor_fix = 1'b0; cor_off = SW'(ncor + 1); cor_mask = 8'hFF;
        end
        out_ready = (cyc % 4) != 1;
        #1;
        isdata = of ? (idx >= OOB) : (idx < PAGE);
        exp_en = rd_ready && rd_valid && isdata;
        chk(calc_en == exp_en, "R2 calc_en", calc_en, exp_en);
        if (exp_en) chk(calc_byte == strm[idx], "R2 calc_byte", calc_byte, strm[idx]);
        if (rd_ready && rd_valid) begin
          if (isdata) begin
            acc_s = acc_s + strm[idx];
            acc_x = acc_x ^ strm[idx];
            dcount++;
          end
          idx++;
        end
        if (calc_req && calc_ack) begin
          chk(dcount == (ncalc + 1) * STEP, "R1 step size", dcount, (ncalc + 1) * STEP);
          chk(clr_cnt == (hw ? ncalc + 1 : 0), "R2 clear per step", clr_cnt,
              hw ? ncalc + 1 : 0);
          calc_mdl[ncalc] = {acc_s, acc_x};
          acc_s = 0; acc_x = 0;
          ncalc++;
        end
        if (cmd_req) chk(of && idx == OOB, "R4 command reissue point", idx, OOB);
        if (cor_req && cor_ack) begin
          chk(int'(cor_step) == ncor, "R3 R4 step order", cor_step, ncor);
          chk(cor_stored == code_of(1'b0, ncor), "R5 stored code", cor_stored,
              code_of(1'b0, ncor));
          chk(cor_calc == code_of(1'b1, ncor), "R1 computed code pairing", cor_calc,
              code_of(1'b1, ncor));
          if (of) chk(idx == OOB + (ncor + 1) * STEP, "R4 correct before next step",
                      idx, OOB + (ncor + 1) * STEP);
          else    chk(idx == PAGE + OOB, "R3 correct after spare area", idx, PAGE + OOB);
          ncor++;
        end
        if (out_valid && out_ready) begin
          expb = (err == nout && !fixable) ? page_dev[nout] : page_ref[nout];
          chk(out_data == expb, fixable ? "R6 released byte" : "R7 released byte",
              out_data, expb);
          if (of) chk(ncor == nout / STEP + 1, "R4 release after own correction",
                      ncor, nout / STEP + 1);
          else    chk(ncor == STEPS, "R3 release after all corrections", ncor, STEPS);
          nout++;
        end
      end
    end
    rd_valid = 0; calc_ack = 0; cmd_ack = 0; cor_ack = 0; out_ready = 0; start = 0;
    @(negedge clk);
    chk(!done, "R9 done is one cycle", done, 0);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk(!rd_ready && !cmd_req && !out_valid, "R11 no restart from mid-run start",
          {rd_ready, cmd_req, out_valid}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; oob_first = 0; hw_ecc = 0; pos_tbl = '0;
    rd_valid = 0; rd_data = 0; cmd_ack = 0; calc_ack = 0; calc_code = 0;
    cor_ack = 0; cor_fix = 0; cor_off = 0; cor_mask = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({rd_ready, cmd_req, calc_clr, calc_req, cor_req, out_valid, done} == 7'd0,
        "R9 reset state", {rd_ready, cmd_req, calc_clr, calc_req, cor_req, out_valid, done}, 0);
    for (int m = 0; m < 4; m++) begin
      for (int e = -1; e < PAGE; e++) begin
        run_case(m[0], m[1], e, (e % 3) != 0, 1 + 2 * ((e + 2 + m) % 4),
                 (e + 1 + 3 * m) % OOB, e + 7 * m + 3);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule